// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block is the translation path of a memory management unit. A 32-bit virtual address arrives on a request port. It is first looked up in a small fully associative translation cache. On a miss, the block walks a two-level table kept in ordinary memory. It reads a directory entry, then the table entry that the directory entry points to, and returns either a physical address or a fault indication.

The virtual address is split into a 10-bit directory index (bits 31:22), a 10-bit table index (bits 21:12) and a 12-bit page offset (bits 11:0); pages are 4 KB. Every entry is 32 bits wide:

- bit 0 marks the entry as present;
- bit 1 permits writes;
- bit 5 records that the page has been used;
- bit 6 records that the page has been written;
- bits 31:12 hold a frame number.

The block writes the used and written marks back into the leaf entry when they need setting. The directory base is a frame number loaded through a strobe. Loading a new base, or pulsing the flush input, empties the translation cache. All memory traffic goes through one request/acknowledge port that carries both reads and writes.

Top module: `ptw_xlate`

## Requirements
- R1: A successful translation returns `{leaf[31:12], vaddr[11:0]}`: the frame number from the leaf entry above the unchanged 12-bit offset.
- R2: On a miss, the block reads the directory word at `{base, vaddr[31:22], 2'b00}`. It then reads the leaf word at `{dir[31:12], vaddr[21:12], 2'b00}`, in that order.
- R3: A translation that hits in the cache and needs no write-back makes no memory access. While the request port is ready, the memory request is low.
- R4: A directory entry with bit 0 clear ends the walk with `rsp_nopage` high, after one memory read and no leaf read.
- R5: A leaf entry with bit 0 clear returns `rsp_nopage` high after two reads. No write-back is made and nothing is cached.
- R6: A write to a page whose bit 1 is clear returns `rsp_noperm` high, with no write-back. This applies whether the leaf comes from a walk or from the cache.
- R7: When bit 5 of the leaf is clear on use, the leaf is written back once with bit 5 set. When bit 5 is already set, a read makes no write.
- R8: The first write to a page whose bit 6 is clear writes the leaf back with bits 5 and 6 set. This holds on the cache-hit path too. Later writes to that page make no memory write.
- R9: A flush pulse invalidates every cached translation, so the next access to any page walks memory again.
- R10: A base-load strobe takes the new directory frame and invalidates the cache. Later walks use the new directory.
- R11: The cache holds 8 translations, filled in round-robin order. With the cache empty, the ninth distinct page fill displaces only the first page filled.
- R12: A memory request holds its address, direction and write data stable until it is acknowledged. `rsp_valid` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| base_wr | input | 1 | Load strobe for the directory base; also empties the cache |
| base_frame | input | 20 | Frame number of the directory |
| flush | input | 1 | Empties the translation cache |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | High when a request can be taken |
| req_vaddr | input | 32 | Virtual address |
| req_write | input | 1 | Request is for a write access |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_paddr | output | 32 | Physical address (valid when no fault flag is set) |
| rsp_nopage | output | 1 | Entry not present at either level |
| rsp_noperm | output | 1 | Write to a write-protected page |
| mem_req | output | 1 | Memory access request, held until acknowledged |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | 32 | Byte address of the entry |
| mem_wdata | output | 32 | Entry value to write |
| mem_ack | input | 1 | Access complete; read data valid this cycle |
| mem_rdata | input | 32 | Entry value read |

## Verification
The assertions take for granted several things about the environment. The memory side answers every request with a single-cycle acknowledge. Flush and base loads arrive only while the block is idle. A request is presented only while `req_ready` is high. The bench drives its request strobe for exactly one cycle when `req_ready` is seen high, and waits for each response before issuing the next request. It pulses flush and base loads only between translations. Its memory responder acknowledges each access once, sometimes after several wait cycles, and counts any change to a pending request while it waits.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
    localparam int VA_W    = 32;
    localparam int OFF_W   = 12;
    localparam int IDX_W   = 10;
    localparam int FRAME_W = VA_W - OFF_W;
    localparam int PTEA_W  = VA_W - 2;

    localparam int BIT_PRESENT = 0;
    localparam int BIT_WRITE   = 1;
    localparam int BIT_USED    = 5;
    localparam int BIT_DIRTY   = 6;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_DIR,
        ST_TBL,
        ST_UPD
    } walk_st_e;
endpackage

// File: rtl/ptw_leaf_eval.sv
module ptw_leaf_eval
    import ptw_pkg::*;
(
    input  logic [VA_W-1:0] entry,
    input  logic            is_write,
    output logic            not_present,
    output logic            no_perm,
    output logic [VA_W-1:0] updated,
    output logic            needs_wb
);
    always_comb begin
        not_present = !entry[BIT_PRESENT];
        no_perm     = entry[BIT_PRESENT] && is_write && !entry[BIT_WRITE];
        updated     = entry;
        updated[BIT_USED] = 1'b1;
        if (is_write) begin
            updated[BIT_DIRTY] = 1'b1;
        end
        needs_wb    = (updated != entry);
    end
endmodule

// File: rtl/ptw_tlb.sv
module ptw_tlb
    import ptw_pkg::*;
#(
    parameter int WAYS = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     inval,
    input  logic [FRAME_W-1:0]       lk_vpn,
    output logic                     hit,
    output logic [$clog2(WAYS)-1:0]  hit_slot,
    output logic [VA_W-1:0]          hit_pte,
    output logic [PTEA_W-1:0]        hit_ptea,
    input  logic                     fill_en,
    input  logic                     fill_use_slot,
    input  logic [$clog2(WAYS)-1:0]  fill_slot,
    input  logic [FRAME_W-1:0]       fill_vpn,
    input  logic [VA_W-1:0]          fill_pte,
    input  logic [PTEA_W-1:0]        fill_ptea
);
    localparam int SW = $clog2(WAYS);

    typedef struct packed {
        logic [WAYS-1:0]               vld;
        logic [WAYS-1:0][FRAME_W-1:0]  vpn;
        logic [WAYS-1:0][VA_W-1:0]     pte;
        logic [WAYS-1:0][PTEA_W-1:0]   ptea;
        logic [SW-1:0]                 rr;
    } tlb_s;

    tlb_s s_d, s_q;
    logic [WAYS-1:0] match;

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        assign match[w] = s_q.vld[w] && (s_q.vpn[w] == lk_vpn);
    end

    always_comb begin
        hit_slot = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (match[w]) begin
                hit_slot = SW'(w);
            end
        end
        hit      = |match;
        hit_pte  = s_q.pte[hit_slot];
        hit_ptea = s_q.ptea[hit_slot];
    end

    always_comb begin
        logic [SW-1:0] slot;
        s_d  = s_q;
        slot = fill_use_slot ? fill_slot : s_q.rr;
        if (inval) begin
            s_d.vld = '0;
        end else if (fill_en) begin
            s_d.vld[slot]  = 1'b1;
            s_d.vpn[slot]  = fill_vpn;
            s_d.pte[slot]  = fill_pte;
            s_d.ptea[slot] = fill_ptea;
            if (!fill_use_slot) begin
                s_d.rr = (s_q.rr == SW'(WAYS - 1)) ? '0 : s_q.rr + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end
endmodule

// File: rtl/ptw_xlate.sv
module ptw_xlate
    import ptw_pkg::*;
#(
    parameter int TLB_WAYS = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                base_wr,
    input  logic [FRAME_W-1:0]  base_frame,
    input  logic                flush,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [VA_W-1:0]     req_vaddr,
    input  logic                req_write,
    output logic                rsp_valid,
    output logic [VA_W-1:0]     rsp_paddr,
    output logic                rsp_nopage,
    output logic                rsp_noperm,
    output logic                mem_req,
    output logic                mem_we,
    output logic [VA_W-1:0]     mem_addr,
    output logic [VA_W-1:0]     mem_wdata,
    input  logic                mem_ack,
    input  logic [VA_W-1:0]     mem_rdata
);
    localparam int SLOT_W = $clog2(TLB_WAYS);

    typedef struct packed {
        walk_st_e              st;
        logic [VA_W-1:0]       vaddr;
        logic                  wr;
        logic [FRAME_W-1:0]    base;
        logic [PTEA_W-1:0]     ptea;
        logic [VA_W-1:0]       pte;
        logic [SLOT_W-1:0]     slot;
        logic                  from_hit;
        logic                  rsp_valid;
        logic [VA_W-1:0]       rsp_paddr;
        logic                  rsp_nopage;
        logic                  rsp_noperm;
    } walk_s;

    walk_s q, n;

    logic                  hit;
    logic [SLOT_W-1:0]     hit_slot;
    logic [VA_W-1:0]       hit_pte;
    logic [PTEA_W-1:0]     hit_ptea;
    logic                  fill_en, fill_use_slot;
    logic [VA_W-1:0]       fill_pte;
    logic [VA_W-1:0]       eval_in, ev_upd;
    logic                  ev_np, ev_noperm, ev_wb;

    assign eval_in  = (q.st == ST_CHECK) ? hit_pte : mem_rdata;
    assign fill_pte = (q.st == ST_TBL) ? mem_rdata : q.pte;

    ptw_leaf_eval u_eval (
        .entry       (eval_in),
        .is_write    (q.wr),
        .not_present (ev_np),
        .no_perm     (ev_noperm),
        .updated     (ev_upd),
        .needs_wb    (ev_wb)
    );

    ptw_tlb #(.WAYS(TLB_WAYS)) u_tlb (
        .clk           (clk),
        .rst_n         (rst_n),
        .inval         (flush || base_wr),
        .lk_vpn        (q.vaddr[VA_W-1:OFF_W]),
        .hit           (hit),
        .hit_slot      (hit_slot),
        .hit_pte       (hit_pte),
        .hit_ptea      (hit_ptea),
        .fill_en       (fill_en),
        .fill_use_slot (fill_use_slot),
        .fill_slot     (q.slot),
        .fill_vpn      (q.vaddr[VA_W-1:OFF_W]),
        .fill_pte      (fill_pte),
        .fill_ptea     (q.ptea)
    );

    always_comb begin
        n               = q;
        n.rsp_valid     = 1'b0;
        n.rsp_nopage    = 1'b0;
        n.rsp_noperm    = 1'b0;
        fill_en         = 1'b0;
        fill_use_slot   = 1'b0;
        if (base_wr) begin
            n.base = base_frame;
        end
        case (q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    n.vaddr = req_vaddr;
                    n.wr    = req_write;
                    n.st    = ST_CHECK;
                end
            end
            ST_CHECK: begin
                if (!hit) begin
                    n.st = ST_DIR;
                end else if (ev_noperm) begin
                    n.rsp_valid  = 1'b1;
                    n.rsp_noperm = 1'b1;
                    n.st         = ST_IDLE;
                end else if (ev_wb) begin
                    n.pte      = ev_upd;
                    n.ptea     = hit_ptea;
                    n.slot     = hit_slot;
                    n.from_hit = 1'b1;
                    n.st       = ST_UPD;
                end else begin
                    n.rsp_valid = 1'b1;
                    n.rsp_paddr = {hit_pte[VA_W-1:OFF_W], q.vaddr[OFF_W-1:0]};
                    n.st        = ST_IDLE;
                end
            end
            ST_DIR: begin
                if (mem_ack) begin
                    if (!mem_rdata[BIT_PRESENT]) begin
                        n.rsp_valid  = 1'b1;
                        n.rsp_nopage = 1'b1;
                        n.st         = ST_IDLE;
                    end else begin
                        n.ptea = {mem_rdata[VA_W-1:OFF_W], q.vaddr[OFF_W+IDX_W-1:OFF_W]};
                        n.st   = ST_TBL;
                    end
                end
            end
            ST_TBL: begin
                if (mem_ack) begin
                    if (ev_np) begin
                        n.rsp_valid  = 1'b1;
                        n.rsp_nopage = 1'b1;
                        n.st         = ST_IDLE;
                    end else if (ev_noperm) begin
                        n.rsp_valid  = 1'b1;
                        n.rsp_noperm = 1'b1;
                        n.st         = ST_IDLE;
                    end else if (ev_wb) begin
                        n.pte      = ev_upd;
                        n.from_hit = 1'b0;
                        n.st       = ST_UPD;
                    end else begin
                        fill_en     = 1'b1;
                        n.rsp_valid = 1'b1;
                        n.rsp_paddr = {mem_rdata[VA_W-1:OFF_W], q.vaddr[OFF_W-1:0]};
                        n.st        = ST_IDLE;
                    end
                end
            end
            ST_UPD: begin
                if (mem_ack) begin
                    fill_en       = 1'b1;
                    fill_use_slot = q.from_hit;
                    n.rsp_valid   = 1'b1;
                    n.rsp_paddr   = {q.pte[VA_W-1:OFF_W], q.vaddr[OFF_W-1:0]};
                    n.st          = ST_IDLE;
                end
            end
            default: n.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= n;
        end
    end

    assign req_ready  = (q.st == ST_IDLE);
    assign mem_req    = (q.st == ST_DIR) || (q.st == ST_TBL) || (q.st == ST_UPD);
    assign mem_we     = (q.st == ST_UPD);
    assign mem_addr   = (q.st == ST_DIR) ? {q.base, q.vaddr[VA_W-1:OFF_W+IDX_W], 2'b00}
                                         : {q.ptea, 2'b00};
    assign mem_wdata  = q.pte;
    assign rsp_valid  = q.rsp_valid;
    assign rsp_paddr  = q.rsp_paddr;
    assign rsp_nopage = q.rsp_nopage;
    assign rsp_noperm = q.rsp_noperm;
endmodule

// File: rtl/ptw_xlate_chk.sv
module ptw_xlate_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_ready,
    input logic [31:0] req_vaddr,
    input logic        req_write,
    input logic        rsp_valid,
    input logic [31:0] rsp_paddr,
    input logic        rsp_nopage,
    input logic        rsp_noperm,
    input logic        mem_req,
    input logic        mem_we,
    input logic [31:0] mem_addr,
    input logic [31:0] mem_wdata,
    input logic        mem_ack
);
    logic [11:0] off_q;
    logic        wr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            off_q <= '0;
            wr_q  <= 1'b0;
        end else if (req_valid && req_ready) begin
            off_q <= req_vaddr[11:0];
            wr_q  <= req_write;
        end
    end

    AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_nopage && !rsp_noperm |-> rsp_paddr[11:0] == off_q); // R1

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !mem_req); // R3

    AST_ONE_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !(rsp_nopage && rsp_noperm)); // R4

    AST_WB_USED: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we |-> mem_wdata[0] && mem_wdata[5]); // R7

    AST_WB_DIRTY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we && wr_q |-> mem_wdata[6]); // R8

    AST_WB_WRITABLE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we && wr_q |-> mem_wdata[1]); // R6

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we)
                                && $stable(mem_wdata)); // R12

    AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid); // R12
endmodule

bind ptw_xlate ptw_xlate_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_vaddr  (req_vaddr),
    .req_write  (req_write),
    .rsp_valid  (rsp_valid),
    .rsp_paddr  (rsp_paddr),
    .rsp_nopage (rsp_nopage),
    .rsp_noperm (rsp_noperm),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_ack    (mem_ack)
);

// File: tb/ptw_xlate_tb.sv
module ptw_xlate_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        base_wr = 1'b0;
    logic [19:0] base_frame = '0;
    logic        flush = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic        req_write = 1'b0;
    logic        rsp_valid;
    logic [31:0] rsp_paddr;
    logic        rsp_nopage, rsp_noperm;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;

    always #2 clk = ~clk;

    ptw_xlate u_dut (
        .clk(clk), .rst_n(rst_n), .base_wr(base_wr), .base_frame(base_frame),
        .flush(flush), .req_valid(req_valid), .req_ready(req_ready),
        .req_vaddr(req_vaddr), .req_write(req_write), .rsp_valid(rsp_valid),
        .rsp_paddr(rsp_paddr), .rsp_nopage(rsp_nopage), .rsp_noperm(rsp_noperm),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    logic [31:0] mem [logic [31:0]];
    int rd_cnt = 0, wr_cnt = 0, hold_err = 0, lat = 0;
    int checks = 0, fails = 0;

    typedef struct {
        logic [31:0] pa;
        bit          np;
        bit          wp;
        int          rd0;
        int          wr0;
        int          erd;
        int          ewr;
        string       tag;
    } exp_t;
    exp_t sbq[$];

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, expv);
        end
    endtask

    function automatic logic [31:0] rdmem(input logic [31:0] a);
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction

    function automatic logic [31:0] leaf_at(input logic [19:0] tf, input logic [31:0] va);
        return {tf, va[21:12], 2'b00};
    endfunction

    task automatic map(input logic [19:0] base, input logic [31:0] va, input logic [19:0] tf,
                       input logic [19:0] frame, input logic [11:0] flags);
        mem[{base, va[31:22], 2'b00}] = {tf, 12'h001};
        mem[leaf_at(tf, va)] = {frame, flags};
    endtask

    // memory responder: single-cycle ack after lat wait cycles
    initial begin
        forever begin
            @(negedge clk);
            if (mem_req && !mem_ack) begin
                logic [31:0] a, d;
                logic w;
                a = mem_addr; d = mem_wdata; w = mem_we;
                for (int k = 0; k < lat; k++) begin
                    @(negedge clk);
                    if (!mem_req || mem_addr != a || mem_we != w || mem_wdata != d) hold_err++;
                end
                if (w) begin
                    mem[a] = d;
                    wr_cnt++;
                end else begin
                    mem_rdata = rdmem(a);
                    rd_cnt++;
                end
                mem_ack = 1'b1;
                @(negedge clk);
                mem_ack = 1'b0;
            end
        end
    end

    // monitor: pops expected items as responses arrive
    initial begin
        forever begin
            @(negedge clk);
            if (rsp_valid) begin
                if (sbq.size() == 0) begin
                    chk(1'b0, "unexpected response", rsp_paddr, 32'h0);
                end else begin
                    exp_t e;
                    e = sbq.pop_front();
                    chk(rsp_nopage == e.np, {e.tag, " nopage"}, 32'(rsp_nopage), 32'(e.np));
                    chk(rsp_noperm == e.wp, {e.tag, " noperm"}, 32'(rsp_noperm), 32'(e.wp));
                    if (!e.np && !e.wp)
                        chk(rsp_paddr == e.pa, {e.tag, " paddr"}, rsp_paddr, e.pa);
                    chk(rd_cnt - e.rd0 == e.erd, {e.tag, " reads"}, 32'(rd_cnt - e.rd0), 32'(e.erd));
                    chk(wr_cnt - e.wr0 == e.ewr, {e.tag, " writes"}, 32'(wr_cnt - e.wr0), 32'(e.ewr));
                end
            end
        end
    end

    task automatic xlate(input logic [31:0] va, input bit wr, input logic [31:0] pa,
                         input bit np, input bit wp, input int erd, input int ewr,
                         input string tag);
        exp_t e;
        e.pa = pa; e.np = np; e.wp = wp; e.erd = erd; e.ewr = ewr; e.tag = tag;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        e.rd0 = rd_cnt; e.wr0 = wr_cnt;
        sbq.push_back(e);
        req_valid = 1'b1; req_vaddr = va; req_write = wr;
        @(negedge clk);
        req_valid = 1'b0;
        while (sbq.size() != 0) @(negedge clk);
    endtask

    task automatic pulse_flush();
        @(negedge clk); flush = 1'b1;
        @(negedge clk); flush = 1'b0;
    endtask

    task automatic load_base(input logic [19:0] b);
        @(negedge clk); base_wr = 1'b1; base_frame = b;
        @(negedge clk); base_wr = 1'b0;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    localparam logic [19:0] B0 = 20'h00100;
    localparam logic [19:0] B1 = 20'h00300;
    localparam logic [31:0] VA1 = 32'h0040_1234;
    localparam logic [31:0] VA_RO = 32'h0040_3abc;

    initial begin
        // page set in first context: dir entries for index 1 point at table frame 0x201
        map(B0, VA1, 20'h00201, 20'h12345, 12'h003);
        mem[leaf_at(20'h00201, 32'h0040_2000)] = 32'h0;
        mem[leaf_at(20'h00201, VA_RO)] = {20'h00abc, 12'h021};

        repeat (3) @(negedge clk);
        chk(req_ready && !rsp_valid && !mem_req, "R12 reset idle",
            {29'd0, req_ready, rsp_valid, mem_req}, 32'h4);
        rst_n = 1'b1;
        load_base(B0);

        xlate(VA1, 1'b0, 32'h1234_5234, 0, 0, 2, 1, "R2 R1 R7 walk read");
        chk(rdmem(leaf_at(20'h00201, VA1)) == {20'h12345, 12'h023}, "R7 used bit written",
            rdmem(leaf_at(20'h00201, VA1)), {20'h12345, 12'h023});
        xlate(VA1, 1'b0, 32'h1234_5234, 0, 0, 0, 0, "R3 hit read");
        xlate(VA1 + 32'h10, 1'b1, 32'h1234_5244, 0, 0, 0, 1, "R8 first write on hit");
        chk(rdmem(leaf_at(20'h00201, VA1)) == {20'h12345, 12'h063}, "R8 dirty bit written",
            rdmem(leaf_at(20'h00201, VA1)), {20'h12345, 12'h063});
        xlate(VA1, 1'b1, 32'h1234_5234, 0, 0, 0, 0, "R8 later write");

        xlate(32'h0080_0000, 1'b0, 32'h0, 1, 0, 1, 0, "R4 directory absent");
        xlate(32'h0040_2000, 1'b0, 32'h0, 1, 0, 2, 0, "R5 leaf absent");
        xlate(32'h0040_2000, 1'b0, 32'h0, 1, 0, 2, 0, "R5 absent not cached");

        xlate(VA_RO, 1'b1, 32'h0, 0, 1, 2, 0, "R6 write protected walk");
        xlate(VA_RO, 1'b0, 32'h00ab_cabc, 0, 0, 2, 0, "R7 used already set");
        xlate(VA_RO, 1'b1, 32'h0, 0, 1, 0, 0, "R6 write protected hit");

        pulse_flush();
        xlate(VA1, 1'b0, 32'h1234_5234, 0, 0, 2, 0, "R9 walk after flush");

        map(B1, VA1, 20'h00401, 20'h55555, 12'h023);
        load_base(B1);
        xlate(VA1, 1'b0, 32'h5555_5234, 0, 0, 2, 0, "R10 new context");

        lat = 3;
        for (int i = 0; i < 9; i++)
            map(B1, 32'(i) << 12, 20'h00400, 20'h60000 + 20'(i), 12'h021);
        pulse_flush();
        for (int i = 0; i < 9; i++)
            xlate(32'(i) << 12, 1'b0, {20'h60000 + 20'(i), 12'h000}, 0, 0, 2, 0, "R11 fill");
        for (int i = 1; i < 9; i++)
            xlate(32'(i) << 12, 1'b0, {20'h60000 + 20'(i), 12'h000}, 0, 0, 0, 0, "R11 kept");
        xlate(32'h0, 1'b0, 32'h6000_0000, 0, 0, 2, 0, "R11 oldest displaced");
        chk(hold_err == 0, "R12 request held while waiting", 32'(hold_err), 32'h0);

        repeat (4) @(negedge clk);
        summary();
    end
endmodule